// File: doc/BRIEF.md
# Serial Byte Master With Slip Detection

This block is the master side of a clocked synchronous serial link. It takes one byte at a time from the host, produces the serial clock, shifts the byte out on the data-out line with the most significant bit first, and shifts a byte in from the data-in line during the same eight clock periods. When the eighth bit has been received, it hands the received byte back to the host on a one-cycle valid strobe.

The slave drives a busy line, and the master watches it for bit slippage. If noise on the serial clock has given the slave an extra or a missing edge, the slave's bit count drifts from the master's. The slave then raises busy, which it does at the end of its own byte, while the master is still inside its byte. The master samples the synchronized busy line once for each falling clock edge of a byte. Any active sample sets a sticky error flag and fires an error interrupt pulse. While the flag is set, the master refuses new bytes until the host clears it.

The host side of the transmit path is a valid/ready stream. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_valid` may be held for as long as the master is not ready, and `tx_ready` is the only back-pressure. The receive path is a plain valid strobe with no ready input, because a result is produced only for a byte the host started, and the host must take `rx_data` in the cycle that `rx_valid` is high.

Top module: `smsd_master`

## Requirements
- R1: `tx_ready` is high exactly when `enable` is high, no byte is in flight and `err_flag` is low. A byte is accepted on an edge where `tx_valid` and `tx_ready` are both high.
- R2: `sck` idles high. After a byte is accepted, `sck` runs eight periods. Each half period lasts H system clocks, where H = `half_div`, raised to 2 when `half_div` is below 2. The first edge is a fall, H clocks after the accepting edge.
- R3: `sdo` carries the accepted byte bit 7 first, down to bit 0. It changes only together with a falling edge of `sck` or at acceptance, and never at a rising edge.
- R4: `sdi` is captured at each rising edge of `sck`, first bit into bit 7. `rx_valid` is high for one system clock, and `rx_data` is valid with it, in the cycle that follows the eighth rising edge. That edge is 16·H clocks after the accepting edge.
- R5: `busy_in` (active high) passes through a two-stage synchronizer. The monitor uses the level `busy_in` had at each of the eight falling edges of a byte, and ignores `busy_in` at all other times, including while idle.
- R6: Any active busy sample sets `err_flag`. `err_irq` pulses for one clock, only for an active sample taken while `err_flag` is still clear, so one slip gives a single pulse.
- R7: `err_flag` stays set until an `err_clear` pulse. If a new active sample and a clear arrive in the same cycle, the flag stays set. While the flag is set, `tx_valid` is ignored.
- R8: When `enable` is low, the master is idle, `tx_ready` is low and `sck` is high from the next clock. Dropping `enable` during a byte aborts it, and no `rx_valid` is produced for it.
- R9: A byte during which slippage is detected still runs to completion and produces its `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Serial interface enable |
| half_div | input | DIV_W | System clocks per serial half period (minimum 2) |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Master can accept a byte |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | One-cycle completion strobe for rx_data |
| err_clear | input | 1 | Write-one-to-clear pulse for err_flag |
| err_flag | output | 1 | Sticky bit-slip error |
| err_irq | output | 1 | One-cycle error interrupt pulse |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy_in | input | 1 | Busy line from the slave, active high |

## Verification
The bound checker watches, on every cycle, the relations that hold between ports at each clock edge. `tx_ready` must never be high while disabled or in error, and `sck` must be high whenever the master is ready. `sdo` must stay put at a rising edge, `rx_valid` and `err_irq` must each last one cycle, the flag must be sticky and must rise only together with the interrupt, and the serial clock must return high after `enable` drops. Only the bench scenarios can show the rest. These are the bit order on both lines, the 16·H latency for several divider settings including the clamp, the detection of a busy level held across falling edges, and the fact that busy outside a byte changes nothing. They also show that starts are refused while in error, that the flag clears on request, and that an aborted byte never reports.

// File: rtl/smsd_pkg.sv
package smsd_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } xfer_state_e;

  // smallest serial half period, in system clocks
  localparam int MIN_HALF = 2;

endpackage

// File: rtl/smsd_sck_gen.sv
module smsd_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             fall_ev,
  output logic             rise_ev
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick    = run && (cnt_q == half - 1'b1);
  assign fall_ev = tick && sck;
  assign rise_ev = tick && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b1;
    end else if (!run) begin
      cnt_q <= '0;
      sck   <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck   <= ~sck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/smsd_shifter.sv
module smsd_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              sdi,
  output logic              sdo,
  output logic              last_rise,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_strobe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CNT_W-1:0]  n_rise;
  logic              shift_ok;
  logic [DATA_W-1:0] rx_next;

  assign sdo       = tx_sh[DATA_W-1];
  assign last_rise = rise_ev && (n_rise == LAST_IDX);
  assign rx_next   = {rx_sh[DATA_W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '1;
      rx_sh     <= '0;
      n_rise    <= '0;
      shift_ok  <= 1'b0;
      rx_byte   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (load) begin
        tx_sh    <= load_byte;
        rx_sh    <= '0;
        n_rise   <= '0;
        shift_ok <= 1'b0;
      end else begin
        // the first fall presents the MSB already loaded; later falls advance
        if (fall_ev && shift_ok) begin
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
        end
        if (rise_ev) begin
          rx_sh    <= rx_next;
          n_rise   <= n_rise + 1'b1;
          shift_ok <= 1'b1;
          if (last_rise) begin
            rx_byte   <= rx_next;
            rx_strobe <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/smsd_slip_mon.sv
module smsd_slip_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  input  logic fall_ev,
  input  logic err_clear,
  output logic err_flag,
  output logic err_irq
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] fall_pipe;
  logic                   hit;

  // busy synchronizer and a matching delay line for the sample strobe
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sync_q[g]    <= 1'b0;
            fall_pipe[g] <= 1'b0;
          end else begin
            sync_q[g]    <= busy_in;
            fall_pipe[g] <= fall_ev;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sync_q[g]    <= 1'b0;
            fall_pipe[g] <= 1'b0;
          end else begin
            sync_q[g]    <= sync_q[g-1];
            fall_pipe[g] <= fall_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  // the delayed strobe meets the busy level as it stood at the fall
  assign hit = fall_pipe[SYNC_STAGES-1] && sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_irq  <= 1'b0;
    end else begin
      err_irq <= hit && !err_flag;
      if (hit) begin
        err_flag <= 1'b1;
      end else if (err_clear) begin
        err_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/smsd_master.sv
module smsd_master #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              err_clear,
  output logic              err_flag,
  output logic              err_irq,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi,
  input  logic              busy_in
);
  import smsd_pkg::*;

  localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(MIN_HALF);

  xfer_state_e      state_q;
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] half_eff;
  logic             accept;
  logic             run;
  logic             fall_ev;
  logic             rise_ev;
  logic             last_rise;

  assign half_eff = (half_div < HALF_FLOOR) ? HALF_FLOOR : half_div;
  assign tx_ready = enable && (state_q == ST_IDLE) && !err_flag;
  assign accept   = tx_valid && tx_ready;
  assign run      = enable && (state_q == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= HALF_FLOOR;
    end else if (!enable) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_SHIFT;
          half_q  <= half_eff;
        end
        ST_SHIFT: if (last_rise) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  smsd_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half    (half_q),
    .sck     (sck),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev)
  );

  smsd_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_byte (tx_data),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .sdi       (sdi),
    .sdo       (sdo),
    .last_rise (last_rise),
    .rx_byte   (rx_data),
    .rx_strobe (rx_valid)
  );

  smsd_slip_mon #(.SYNC_STAGES(SYNC_STAGES)) u_slip (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_in   (busy_in),
    .fall_ev   (fall_ev),
    .err_clear (err_clear),
    .err_flag  (err_flag),
    .err_irq   (err_irq)
  );

endmodule

// File: rtl/smsd_chk.sv
module smsd_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tx_ready,
  input logic rx_valid,
  input logic err_clear,
  input logic err_flag,
  input logic err_irq,
  input logic sck,
  input logic sdo
);

  // R1
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (enable && !err_flag));

  // R2
  idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> sck);

  // R3
  sdo_hold_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(sdo));

  // R4
  rx_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  irq_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);

  // R6
  flag_rise_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> err_irq);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag);

  // R8
  disabled_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> sck);

  // R8
  disabled_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tx_ready);

endmodule

bind smsd_master smsd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .err_clear (err_clear),
  .err_flag  (err_flag),
  .err_irq   (err_irq),
  .sck       (sck),
  .sdo       (sdo)
);

// File: tb/smsd_master_test.sv
module smsd_master_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic [7:0] half_div = 8'd2;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       err_clear = 1'b0;
  logic       err_flag;
  logic       err_irq;
  logic       sck;
  logic       sdo;
  logic       sdi = 1'b0;
  logic       busy_in = 1'b0;

  always #5 clk = ~clk;

  smsd_master uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_clear(err_clear),
    .err_flag(err_flag), .err_irq(err_irq), .sck(sck), .sdo(sdo),
    .sdi(sdi), .busy_in(busy_in)
  );

  typedef struct {
    logic [7:0] rx_exp;
    logic [7:0] tx_exp;
    int         half;
    int         acc;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int rxv_cnt = 0;
  logic [7:0] slv_tx = 8'h00;
  logic [7:0] slv_rx = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model: next bit on each falling edge, capture sdo on each rising edge
  always @(negedge sck) begin
    sdi = slv_tx[7];
    slv_tx = {slv_tx[6:0], 1'b0};
  end
  always @(posedge sck) slv_rx = {slv_rx[6:0], sdo};

  // monitor / scoreboard
  always @(negedge clk) begin
    if (err_irq) irq_cnt++;
    if (rst_n && rx_valid) begin
      rxv_cnt++;
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected rx_valid", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(rx_data == it.rx_exp, "R4 rx_data", rx_data, it.rx_exp);
        check(slv_rx == it.tx_exp, "R3 sdo byte", slv_rx, it.tx_exp);
        check((cyc - it.acc) == 16 * it.half, "R2 latency", cyc - it.acc, 16 * it.half);
      end
    end
  end

  task automatic start_byte(input logic [7:0] tb, input logic [7:0] sb, output int acc);
    @(negedge clk);
    slv_tx = sb;
    slv_rx = 8'h00;
    tx_data = tb;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] tb, input logic [7:0] sb, input int h);
    int acc;
    item_t it;
    half_div = h[7:0];
    start_byte(tb, sb, acc);
    it.rx_exp = sb;
    it.tx_exp = tb;
    it.half = (h < 2) ? 2 : h;
    it.acc = acc;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    int acc;
    int irq0;
    int rxv0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 reset state
    check(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    check(sck == 1'b1, "R2 sck idles high", sck, 1);
    check(err_flag == 1'b0, "R6 flag clear after reset", err_flag, 0);
    check(rx_valid == 1'b0, "R4 no rx after reset", rx_valid, 0);

    // R2 R3 R4 several patterns and dividers (0 clamps to 2)
    send(8'hA5, 8'h3C, 2);
    send(8'h00, 8'hFF, 3);
    send(8'hFF, 8'h00, 5);
    send(8'h81, 8'h7E, 0);
    send(8'h5A, 8'hC3, 4);

    // R5 busy while idle is ignored
    busy_in = 1'b1;
    repeat (30) @(negedge clk);
    busy_in = 1'b0;
    repeat (4) @(negedge clk);
    check(err_flag == 1'b0, "R5 idle busy ignored", err_flag, 0);
    check(irq_cnt == 0, "R5 no irq from idle busy", irq_cnt, 0);
    send(8'h96, 8'h69, 3);
    check(err_flag == 1'b0, "R5 clean byte no error", err_flag, 0);

    // R6 R9 busy held across two falling edges mid-byte
    fork
      send(8'hC7, 8'h1E, 3);
      begin
        repeat (3) @(posedge sck);
        busy_in = 1'b1;
        repeat (2) @(posedge sck);
        busy_in = 1'b0;
      end
    join
    check(err_flag == 1'b1, "R6 flag set on slip", err_flag, 1);
    check(irq_cnt == 1, "R6 single irq pulse", irq_cnt, 1);
    check(tx_ready == 1'b0, "R7 not ready while in error", tx_ready, 0);
    check(rxv_cnt == 7, "R9 erroneous byte completed", rxv_cnt, 7);

    // R7 starts ignored while flag set
    rxv0 = rxv_cnt;
    tx_valid = 1'b1;
    repeat (60) @(negedge clk);
    check(sck == 1'b1, "R7 no transfer while in error", sck, 1);
    check(err_flag == 1'b1, "R7 flag sticky", err_flag, 1);
    tx_valid = 1'b0;
    check(rxv_cnt == rxv0, "R7 no rx while in error", rxv_cnt, rxv0);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check(err_flag == 1'b0, "R7 flag cleared", err_flag, 0);
    check(tx_ready == 1'b1, "R1 ready after clear", tx_ready, 1);
    send(8'h33, 8'hCC, 2);

    // R8 enable low: not ready, abort in flight
    irq0 = irq_cnt;
    enable = 1'b0;
    @(negedge clk);
    check(tx_ready == 1'b0, "R8 not ready when disabled", tx_ready, 0);
    enable = 1'b1;
    half_div = 8'd4;
    start_byte(8'hE1, 8'h11, acc);
    repeat (20) @(negedge clk);
    rxv0 = rxv_cnt;
    enable = 1'b0;
    @(negedge clk);
    check(sck == 1'b1, "R8 sck high after disable", sck, 1);
    repeat (80) @(negedge clk);
    check(rxv_cnt == rxv0, "R8 aborted byte no rx", rxv_cnt, rxv0);
    check(irq_cnt == irq0, "R8 no irq on abort", irq_cnt, irq0);
    enable = 1'b1;
    @(negedge clk);
    send(8'h4B, 8'hB4, 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule